// File: doc/BRIEF.md
# Accumulator Operate Microinstruction Unit

This unit executes the operate-class instructions of a 12-bit accumulator machine. A sequencer presents a 12-bit instruction word, the accumulator, the link bit and the front-panel switch value, and pulses `start`. The unit returns the new accumulator and link. It also returns a skip flag, which tells the sequencer to step the program counter past the next word, and a halt flag. All of these are valid in the cycle where `done` is high.

Operate words have `7` in the top octal digit. Octal bit `0400` picks the group. Group 1 holds clear, complement, increment and rotate through the link. Group 2 holds the conditional skips, the switch OR and halt. Bits within a word combine freely and are applied in a fixed order. Words with any other top digit pass through unchanged, so the sequencer can route every word here without harm.

Top module: `acc_operate_unit`

## Requirements
- R1: After reset, `done`, `skip`, `halt`, `link_out` and `acc_out` are all zero.
- R2: Only words whose top octal digit is 7 are operate words, and octal bit 0400 selects group 2 when set and group 1 when clear. Any other word completes in one cycle with accumulator and link passed through, and with no skip and no halt.
- R3: In group 1, octal 0200 clears AC, 0100 clears link, 0040 complements AC and 0020 complements link. They apply in the order clear, complement, increment, rotate, so 7041 negates AC, 7240 gives 7777, and 7204 moves the link into AC bit 0.
- R4: Group 1 bit 0001 increments AC modulo 4096. A carry out of 7777 complements the link.
- R5: Group 1 rotates the 13-bit value {link, AC}. Bit 0010 rotates right and bit 0004 rotates left, and bit 0002 makes it two places instead of one. If both direction bits are set, no rotate happens. Bit 0002 with no direction bit has no effect.
- R6: A result appears with `done` one cycle after `start` is taken. When a rotate is encoded it appears two cycles after. `done` is a one-cycle pulse, and `start` is ignored while a rotate is in progress.
- R7: In group 2 with sense bit 0010 clear, the skip is the OR of the selected tests: 0100 AC negative (bit 11 set), 0040 AC zero, 0020 link set.
- R8: In group 2 with sense bit 0010 set, each selected test is inverted and the results are ANDed. The sense bit with no test selected skips unconditionally.
- R9: Group 2 evaluates the skip tests on the incoming AC. Then 0200 clears AC, and then 0004 ORs the switch value into AC. The link leaves group 2 unchanged.
- R10: Group 2 bit 0002 raises `halt`. `skip` and `halt` are zero in every cycle where `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Take the word and operands on this edge |
| instr | input | 12 | Instruction word |
| acc_in | input | 12 | Current accumulator |
| link_in | input | 1 | Current link bit |
| sw | input | 12 | Switch register value |
| done | output | 1 | Result valid (one-cycle pulse) |
| acc_out | output | 12 | New accumulator |
| link_out | output | 1 | New link bit |
| skip | output | 1 | Skip the next instruction word |
| halt | output | 1 | Stop the machine |

## Verification
Every one of the 512 operate codes is run against accumulator values 0000, 0001, 3777, 4000, 7777 and 2525, each with both link values. This separates sign, zero and carry boundaries for every bit combination, and it catches ordering errors among clear, complement, increment and rotate. A spread of non-operate words shows pass-through. Hand-worked words then check the documented combinations on their own: negate, set to all ones, link to bit 0, single and double rotates, conflicting directions, skip-before-clear, switch load, OR versus inverted AND, and halt. A separate sequence raises `start` during a rotate to show that the second request is dropped.

// File: rtl/acc_operate_unit.sv
module acc_operate_unit #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] instr,
  input  logic [W-1:0] acc_in,
  input  logic         link_in,
  input  logic [W-1:0] sw,
  output logic         done,
  output logic [W-1:0] acc_out,
  output logic         link_out,
  output logic         skip,
  output logic         halt
);
  localparam int OPW = 3;

  logic         busy, rot_left, rot_two;
  logic [W-1:0] acc_r;
  logic         link_r, done_r, skip_r, halt_r;

  wire is_opr = instr[W-1 -: OPW] == {OPW{1'b1}};
  wire grp2   = is_opr &  instr[8];
  wire grp1   = is_opr & ~instr[8];

  wire [W-1:0] a_clr = instr[7] ? '0 : acc_in;
  wire         l_clr = instr[6] ? 1'b0 : link_in;
  wire [W-1:0] a_cmp = instr[5] ? ~a_clr : a_clr;
  wire         l_cmp = instr[4] ^ l_clr;
  wire [W:0]   a_inc = {1'b0, a_cmp} + {{W{1'b0}}, instr[0]};
  wire         l_inc = l_cmp ^ a_inc[W];
  wire         do_rot = grp1 & (instr[3] ^ instr[2]);

  wire cond  = (instr[6] & acc_in[W-1]) | (instr[5] & (acc_in == '0)) | (instr[4] & link_in);
  wire g2_sk = instr[3] ? ~cond : cond;
  wire [W-1:0] g2_acc = a_clr | (instr[2] ? sw : '0);

  wire [W:0] v0 = {link_r, acc_r};
  wire [W:0] v1 = rot_left ? {v0[W-1:0], v0[W]} : {v0[0], v0[W:1]};
  wire [W:0] v2 = rot_left ? {v1[W-1:0], v1[W]} : {v1[0], v1[W:1]};
  wire [W:0] vr = rot_two ? v2 : v1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      rot_left <= 1'b0;
      rot_two  <= 1'b0;
      acc_r    <= '0;
      link_r   <= 1'b0;
      done_r   <= 1'b0;
      skip_r   <= 1'b0;
      halt_r   <= 1'b0;
    end else begin
      done_r <= 1'b0;
      skip_r <= 1'b0;
      halt_r <= 1'b0;
      if (busy) begin
        {link_r, acc_r} <= vr;
        busy   <= 1'b0;
        done_r <= 1'b1;
      end else if (start) begin
        if (grp2) begin
          acc_r  <= g2_acc;
          link_r <= link_in;
          skip_r <= g2_sk;
          halt_r <= instr[1];
          done_r <= 1'b1;
        end else if (grp1) begin
          acc_r    <= a_inc[W-1:0];
          link_r   <= l_inc;
          rot_left <= instr[2];
          rot_two  <= instr[1];
          busy     <= do_rot;
          done_r   <= ~do_rot;
        end else begin
          acc_r  <= acc_in;
          link_r <= link_in;
          done_r <= 1'b1;
        end
      end
    end
  end

  assign done     = done_r;
  assign acc_out  = acc_r;
  assign link_out = link_r;
  assign skip     = skip_r;
  assign halt     = halt_r;
endmodule

// File: rtl/acc_operate_unit_chk.sv
module acc_operate_unit_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [W-1:0] instr,
  input logic [W-1:0] acc_in,
  input logic         link_in,
  input logic         done,
  input logic [W-1:0] acc_out,
  input logic         link_out,
  input logic         skip,
  input logic         halt,
  input logic         busy
);
  wire take   = start & ~busy;
  wire opr    = instr[W-1 -: 3] == 3'b111;
  wire g2     = opr & instr[8];
  wire rot    = opr & ~instr[8] & (instr[3] ^ instr[2]);

  a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    take && !rot |=> done);
  a_r6_rot_two: assert property (@(posedge clk) disable iff (!rst_n)
    take && rot |=> (!done ##1 done));
  a_r10_flags_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (!skip && !halt));
  a_r9_link_kept: assert property (@(posedge clk) disable iff (!rst_n)
    take && g2 |=> link_out == $past(link_in));
  a_r10_halt: assert property (@(posedge clk) disable iff (!rst_n)
    take && g2 |=> halt == $past(instr[1]));
  a_r2_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    take && !opr |=> (acc_out == $past(acc_in) && link_out == $past(link_in) && !skip));
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    take && instr == 12'o7001 && acc_in == 12'o7777 |=> (acc_out == '0 && link_out == !$past(link_in)));
endmodule

bind acc_operate_unit acc_operate_unit_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .acc_in(acc_in),
  .link_in(link_in), .done(done), .acc_out(acc_out), .link_out(link_out),
  .skip(skip), .halt(halt), .busy(busy)
);

// File: tb/acc_operate_unit_tb_top.sv
`timescale 1ns/1ps
module acc_operate_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] instr = '0, acc_in = '0, sw = '0;
  logic        link_in = 1'b0;
  logic        done, link_out, skip, halt;
  logic [11:0] acc_out;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [11:0] o_acc;
  logic        o_lnk, o_skp, o_hlt;
  int          o_cyc;

  always #2 clk = ~clk;

  acc_operate_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .acc_in(acc_in),
    .link_in(link_in), .sw(sw), .done(done), .acc_out(acc_out),
    .link_out(link_out), .skip(skip), .halt(halt)
  );

  task automatic run(input logic [11:0] i, input logic [11:0] a, input logic l, input logic [11:0] s);
    @(negedge clk);
    instr = i; acc_in = a; link_in = l; sw = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    o_cyc = 1;
    while (!done && o_cyc < 6) begin
      @(negedge clk);
      o_cyc++;
    end
    o_acc = acc_out; o_lnk = link_out; o_skp = skip; o_hlt = halt;
  endtask

  task automatic model(input logic [11:0] i, input logic [11:0] a0, input logic l0, input logic [11:0] s,
                       output logic [11:0] ea, output logic el, output logic es, output logic eh, output int ec);
    int a = a0, lk = l0, v;
    es = 0; eh = 0; ec = 1;
    if (i[11:9] == 3'o7 && !i[8]) begin
      if (i & 12'o0200) a = 0;
      if (i & 12'o0100) lk = 0;
      if (i & 12'o0040) a = 4095 - a;
      if (i & 12'o0020) lk = 1 - lk;
      if (i & 12'o0001) begin
        if (a == 4095) begin a = 0; lk = 1 - lk; end else a = a + 1;
      end
      if (i[3] != i[2]) begin
        ec = 2;
        v = lk * 4096 + a;
        for (int k = 0; k < (i[1] ? 2 : 1); k++)
          v = i[2] ? (((v << 1) & 8191) | (v >> 12)) : ((v >> 1) | ((v & 1) << 12));
        lk = v / 4096; a = v % 4096;
      end
    end else if (i[11:9] == 3'o7) begin
      if (i[3]) es = (!i[6] || a < 2048) && (!i[5] || a != 0) && (!i[4] || lk == 0);
      else      es = (i[6] && a >= 2048) || (i[5] && a == 0) || (i[4] && lk == 1);
      if (i[7]) a = 0;
      if (i[2]) a = a | s;
      eh = i[1];
    end
    ea = a[11:0]; el = lk[0];
  endtask

  task automatic expect_res(input string tag, input logic [11:0] i,
                            input logic [11:0] ea, input logic el, input logic es, input logic eh, input int ec);
    checks++;
    if (o_acc !== ea || o_lnk !== el || o_skp !== es || o_hlt !== eh || o_cyc != ec) begin
      fails++;
      $display("FAIL %s instr=%o actual acc=%o l=%b s=%b h=%b cyc=%0d expected acc=%o l=%b s=%b h=%b cyc=%0d",
               tag, i, o_acc, o_lnk, o_skp, o_hlt, o_cyc, ea, el, es, eh, ec);
    end
  endtask

  task automatic hand(input string tag, input logic [11:0] i, input logic [11:0] a, input logic l, input logic [11:0] s,
                      input logic [11:0] ea, input logic el, input logic es, input logic eh, input int ec);
    run(i, a, l, s);
    expect_res(tag, i, ea, el, es, eh, ec);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [11:0] accs [6] = '{12'o0000, 12'o0001, 12'o3777, 12'o4000, 12'o7777, 12'o2525};
    logic [11:0] ea; logic el, es, eh; int ec;
    repeat (3) @(negedge clk);
    checks++;
    if (done !== 0 || skip !== 0 || halt !== 0 || link_out !== 0 || acc_out !== 0) begin
      fails++;
      $display("FAIL R1 reset actual done=%b skip=%b halt=%b l=%b acc=%o expected all zero",
               done, skip, halt, link_out, acc_out);
    end
    rst_n = 1'b1;

    for (int c = 0; c < 512; c++)
      for (int k = 0; k < 6; k++)
        for (int l = 0; l < 2; l++) begin
          logic [11:0] iw = 12'o7000 | c[11:0];
          logic [11:0] s = accs[k] ^ 12'o1234;
          run(iw, accs[k], l[0], s);
          model(iw, accs[k], l[0], s, ea, el, es, eh, ec);
          expect_res(iw[8] ? "R7/R8/R9/R10 sweep" : "R3/R4/R5/R6 sweep", iw, ea, el, es, eh, ec);
        end

    for (int c = 0; c < 12'o7000; c += 12'o0321) begin
      run(c[11:0], 12'o5432, 1'b1, 12'o7777);
      expect_res("R2 non-operate", c[11:0], 12'o5432, 1'b1, 1'b0, 1'b0, 1);
    end

    hand("R2 group1 0400 clear", 12'o7300, 12'o1234, 1'b1, 12'o0, 12'o0000, 1'b0, 1'b0, 1'b0, 1);
    hand("R3 negate",            12'o7041, 12'o0005, 1'b0, 12'o0, 12'o7773, 1'b0, 1'b0, 1'b0, 1);
    hand("R3 all ones",          12'o7240, 12'o1234, 1'b1, 12'o0, 12'o7777, 1'b1, 1'b0, 1'b0, 1);
    hand("R3 link to bit0",      12'o7204, 12'o5555, 1'b1, 12'o0, 12'o0001, 1'b0, 1'b0, 1'b0, 2);
    hand("R4 wrap",              12'o7001, 12'o7777, 1'b0, 12'o0, 12'o0000, 1'b1, 1'b0, 1'b0, 1);
    hand("R5 right two",         12'o7012, 12'o0001, 1'b0, 12'o0, 12'o4000, 1'b0, 1'b0, 1'b0, 2);
    hand("R5 left two",          12'o7006, 12'o4000, 1'b0, 12'o0, 12'o0001, 1'b0, 1'b0, 1'b0, 2);
    hand("R5 both directions",   12'o7014, 12'o1234, 1'b1, 12'o0, 12'o1234, 1'b1, 1'b0, 1'b0, 1);
    hand("R5 double alone",      12'o7002, 12'o1234, 1'b0, 12'o0, 12'o1234, 1'b0, 1'b0, 1'b0, 1);
    hand("R7 zero or link",      12'o7460, 12'o0123, 1'b1, 12'o0, 12'o0123, 1'b1, 1'b1, 1'b0, 1);
    hand("R7 zero or link none", 12'o7460, 12'o0123, 1'b0, 12'o0, 12'o0123, 1'b0, 1'b0, 1'b0, 1);
    hand("R8 nonneg and link0",  12'o7530, 12'o3777, 1'b0, 12'o0, 12'o3777, 1'b0, 1'b1, 1'b0, 1);
    hand("R8 negative fails",    12'o7530, 12'o4000, 1'b0, 12'o0, 12'o4000, 1'b0, 1'b0, 1'b0, 1);
    hand("R8 positive zero",     12'o7550, 12'o0000, 1'b0, 12'o0, 12'o0000, 1'b0, 1'b0, 1'b0, 1);
    hand("R8 positive one",      12'o7550, 12'o0001, 1'b0, 12'o0, 12'o0001, 1'b0, 1'b1, 1'b0, 1);
    hand("R8 unconditional",     12'o7410, 12'o4321, 1'b1, 12'o0, 12'o4321, 1'b1, 1'b1, 1'b0, 1);
    hand("R9 skip before clear", 12'o7640, 12'o0000, 1'b0, 12'o0, 12'o0000, 1'b0, 1'b1, 1'b0, 1);
    hand("R9 no skip, cleared",  12'o7640, 12'o0012, 1'b0, 12'o0, 12'o0000, 1'b0, 1'b0, 1'b0, 1);
    hand("R9 load switches",     12'o7604, 12'o1111, 1'b1, 12'o2345, 12'o2345, 1'b1, 1'b0, 1'b0, 1);
    hand("R10 halt",             12'o7402, 12'o0777, 1'b0, 12'o0, 12'o0777, 1'b0, 1'b0, 1'b1, 1);

    @(negedge clk);
    instr = 12'o7010; acc_in = 12'o0002; link_in = 1'b0; start = 1'b1;
    @(negedge clk);
    instr = 12'o7200; acc_in = 12'o7777;
    @(negedge clk);
    start = 1'b0;
    checks++;
    if (done !== 1 || acc_out !== 12'o0001 || link_out !== 1'b0) begin
      fails++;
      $display("FAIL R6 busy start actual done=%b acc=%o l=%b expected done=1 acc=0001 l=0", done, acc_out, link_out);
    end
    @(negedge clk);
    checks++;
    if (done !== 0 || acc_out !== 12'o0001) begin
      fails++;
      $display("FAIL R6 dropped start actual done=%b acc=%o expected done=0 acc=0001", done, acc_out);
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule